// File: doc/BRIEF.md
# Digital Input Conditioner

This block cleans up a small group of digital input lines before downstream logic (software-visible status or trigger event selection) consumes them. Each raw line first passes through a two-stage synchronizer. An optional exchange of two fixed line positions follows. A deglitch filter then accepts a new level only after the level has been stable for a whole window. Finally a per-line polarity mask is applied. The window length is picked by a static control bit: a short window of 4 clocks or a long window of 8 clocks. At a 40 MHz timing base these are 100 ns and 200 ns.

Alongside the conditioned levels, the block produces a one-clock strobe per line when the conditioned level rises because the filter accepted a new level. Event-selection logic can use this strobe directly. All configuration inputs are treated as quasi-static register bits. The reset is asynchronous and active-low. Its release is synchronized inside the block, so the filters leave reset two clocks after `rst_n` rises.

Top module: `din_cond`

## Requirements
- R1: `dout_level[i]` equals the filtered level of line i XOR `cfg_invert[i]`. The inversion is applied after filtering, so a change of `cfg_invert` shows on `dout_level` in the same cycle without passing through the filter.
- R2: Each raw line is sampled by two flip-flops before the filter. A raw change held long enough appears on `dout_level` at the (2+W)-th rising clock edge after it is first sampled, where W is the active window.
- R3: With `cfg_long_filt`=0 the window W is 4 clocks. A raw pulse lasting 3 clocks is rejected, and one lasting 4 clocks is accepted.
- R4: With `cfg_long_filt`=1 the window W is 8 clocks. A raw pulse lasting 7 clocks is rejected, and one lasting 8 clocks is accepted.
- R5: With `cfg_swap_en`=1, output position 1 is conditioned from raw input 3 and output position 3 from raw input 1. With `cfg_swap_en`=0 every position uses its own input. Other positions are never affected. The exchange is made before filtering.
- R6: Any return of the synchronized input to the currently accepted level restarts the window count. Two 3-clock pulses separated by a 1-clock gap are rejected in short mode.
- R7: `dout_rise[i]` is high for exactly one clock, in the cycle in which the filtered level of line i changes and the resulting `dout_level[i]` is 1. A polarity change alone produces no strobe.
- R8: While `rst_n` is low, and until two rising edges after it goes high, all filtered levels are 0 (`dout_level` equals `cfg_invert`), all filter counters are cleared, and `dout_rise` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronized internally |
| cfg_long_filt | input | 1 | 0: 4-clock window, 1: 8-clock window |
| cfg_swap_en | input | 1 | 1: exchange input positions 1 and 3 before filtering |
| cfg_invert | input | N_LINES | Per-line polarity mask applied after filtering |
| din_raw | input | N_LINES | Asynchronous raw input lines |
| dout_level | output | N_LINES | Conditioned levels |
| dout_rise | output | N_LINES | One-clock strobe when a conditioned level rises |

## Verification
The hardest case to reach from the ports is a pulse whose length sits exactly at the window boundary, or a bounce that arrives one clock before the count would finish. Random toggling almost never lands there. Directed pulses of W-1 and W clocks in both window modes, and a pulse–gap–pulse bounce pattern, place the synchronized input on those exact edges. Sparse random toggling with occasional configuration changes then covers swap and polarity interaction against a cycle-level reference model in the bench.

// File: rtl/din_cond_pkg.sv
package din_cond_pkg;

  typedef enum logic {
    WIN_SHORT = 1'b0,
    WIN_LONG  = 1'b1
  } win_sel_e;

  // Number of consecutive stable samples required for the selected window.
  function automatic int win_cycles(win_sel_e sel, int short_w, int long_w);
    return (sel == WIN_LONG) ? long_w : short_w;
  endfunction

endpackage

// File: rtl/din_cond_rst.sv
module din_cond_rst (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign rst_sync_n = stage_q[1];

endmodule

// File: rtl/din_cond_sync.sv
module din_cond_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);

  logic [WIDTH-1:0] chain_q [STAGES];
  logic [WIDTH-1:0] chain_d [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_comb chain_d[s] = d_async;
      end else begin : g_next
        always_comb chain_d[s] = chain_q[s-1];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          chain_q[s] <= '0;
        end else begin
          chain_q[s] <= chain_d[s];
        end
      end
    end
  endgenerate

  assign q_sync = chain_q[STAGES-1];

endmodule

// File: rtl/din_cond_filt.sv
module din_cond_filt
  import din_cond_pkg::*;
#(
  parameter int SHORT_WIN = 4,
  parameter int LONG_WIN  = 8
) (
  input  logic     clk,
  input  logic     rst_n,
  input  win_sel_e win_sel,
  input  logic     samp,
  output logic     level,
  output logic     rise
);

  localparam int CNT_W = $clog2(LONG_WIN + 1);
  localparam logic [CNT_W-1:0] SHORT_LIM = CNT_W'(SHORT_WIN - 1);
  localparam logic [CNT_W-1:0] LONG_LIM  = CNT_W'(LONG_WIN - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             lvl_q, lvl_d;
  logic             lvl_prev_q;
  logic             cnt_en;
  logic [CNT_W-1:0] lim;

  always_comb begin
    lim = (win_cycles(win_sel, SHORT_WIN, LONG_WIN) == LONG_WIN) ? LONG_LIM : SHORT_LIM;
  end

  // Next-state: count samples that disagree with the accepted level.
  always_comb begin
    cnt_d = cnt_q;
    lvl_d = lvl_q;
    if (samp == lvl_q) begin
      cnt_d = '0;
    end else if (cnt_q >= lim) begin
      lvl_d = samp;
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  assign cnt_en = (samp != lvl_q) || (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lvl_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
      lvl_q <= lvl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_prev_q <= 1'b0;
    end else begin
      lvl_prev_q <= lvl_q;
    end
  end

  assign level = lvl_q;
  assign rise  = lvl_q ^ lvl_prev_q;

endmodule

// File: rtl/din_cond.sv
module din_cond
  import din_cond_pkg::*;
#(
  parameter int N_LINES     = 4,
  parameter int SHORT_WIN   = 4,
  parameter int LONG_WIN    = 8,
  parameter int SYNC_STAGES = 2,
  parameter int SWAP_LO     = 1,
  parameter int SWAP_HI     = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_long_filt,
  input  logic               cfg_swap_en,
  input  logic [N_LINES-1:0] cfg_invert,
  input  logic [N_LINES-1:0] din_raw,
  output logic [N_LINES-1:0] dout_level,
  output logic [N_LINES-1:0] dout_rise
);

  logic               rst_i;
  logic [N_LINES-1:0] sync_q;
  logic [N_LINES-1:0] swap_vec;
  logic [N_LINES-1:0] filt_lvl;
  logic [N_LINES-1:0] filt_chg;
  win_sel_e           win_sel;

  assign win_sel = cfg_long_filt ? WIN_LONG : WIN_SHORT;

  din_cond_rst u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i)
  );

  din_cond_sync #(
    .WIDTH  (N_LINES),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_i),
    .d_async (din_raw),
    .q_sync  (sync_q)
  );

  genvar i;
  generate
    for (i = 0; i < N_LINES; i++) begin : g_line
      // Position exchange ahead of the filter.
      if (i == SWAP_LO) begin : g_lo
        assign swap_vec[i] = cfg_swap_en ? sync_q[SWAP_HI] : sync_q[i];
      end else if (i == SWAP_HI) begin : g_hi
        assign swap_vec[i] = cfg_swap_en ? sync_q[SWAP_LO] : sync_q[i];
      end else begin : g_pass
        assign swap_vec[i] = sync_q[i];
      end

      din_cond_filt #(
        .SHORT_WIN (SHORT_WIN),
        .LONG_WIN  (LONG_WIN)
      ) u_filt (
        .clk     (clk),
        .rst_n   (rst_i),
        .win_sel (win_sel),
        .samp    (swap_vec[i]),
        .level   (filt_lvl[i]),
        .rise    (filt_chg[i])
      );

      assign dout_level[i] = filt_lvl[i] ^ cfg_invert[i];
      assign dout_rise[i]  = filt_chg[i] & dout_level[i];
    end
  endgenerate

endmodule

// File: rtl/din_cond_chk.sv
module din_cond_chk #(
  parameter int N_LINES   = 4,
  parameter int SHORT_WIN = 4,
  parameter int LONG_WIN  = 8,
  parameter int SWAP_LO   = 1,
  parameter int SWAP_HI   = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               rst_i,
  input logic               cfg_long_filt,
  input logic               cfg_swap_en,
  input logic [N_LINES-1:0] sync_q,
  input logic [N_LINES-1:0] swap_vec,
  input logic [N_LINES-1:0] filt_lvl,
  input logic [N_LINES-1:0] dout_level,
  input logic [N_LINES-1:0] dout_rise
);

  localparam int RW = $clog2(LONG_WIN + 2);
  localparam logic [RW-1:0] RUN_MAX = RW'(LONG_WIN);

  // R8: filtered state is clear while the internal reset is held
  always @(posedge clk) begin
    if (rst_n && !rst_i) begin
      assert_reset_clear_R8: assert (filt_lvl == '0 && dout_rise == '0)
        else $error("filter state not clear during reset");
    end
  end

  // R5: position exchange in front of the filter
  assert_swap_map_R5: assert property (@(posedge clk) disable iff (!rst_i)
    cfg_swap_en |-> (swap_vec[SWAP_LO] == sync_q[SWAP_HI] && swap_vec[SWAP_HI] == sync_q[SWAP_LO]));

  assert_noswap_map_R5: assert property (@(posedge clk) disable iff (!rst_i)
    !cfg_swap_en |-> (swap_vec == sync_q));

  genvar i;
  generate
    for (i = 0; i < N_LINES; i++) begin : g_chk
      logic [RW-1:0] run_q;
      logic          last_q;

      always_ff @(posedge clk or negedge rst_i) begin
        if (!rst_i) begin
          run_q  <= '0;
          last_q <= 1'b0;
        end else begin
          last_q <= swap_vec[i];
          if (swap_vec[i] != last_q) begin
            run_q <= RW'(1);
          end else if (run_q != RUN_MAX) begin
            run_q <= run_q + 1'b1;
          end
        end
      end

      // R2/R6: accepted level only after a full uninterrupted window
      assert_stable_window_R6: assert property (@(posedge clk) disable iff (!rst_i)
        (filt_lvl[i] != $past(filt_lvl[i])) |->
          (last_q == filt_lvl[i] &&
           int'(run_q) >= ($past(cfg_long_filt) ? LONG_WIN : SHORT_WIN)));

      // R7: strobe only with a high level, never two cycles running
      assert_rise_level_R7: assert property (@(posedge clk) disable iff (!rst_i)
        dout_rise[i] |-> dout_level[i]);

      assert_rise_single_R7: assert property (@(posedge clk) disable iff (!rst_i)
        dout_rise[i] |=> !dout_rise[i]);
    end
  endgenerate

endmodule

bind din_cond din_cond_chk #(
  .N_LINES   (N_LINES),
  .SHORT_WIN (SHORT_WIN),
  .LONG_WIN  (LONG_WIN),
  .SWAP_LO   (SWAP_LO),
  .SWAP_HI   (SWAP_HI)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .rst_i         (rst_i),
  .cfg_long_filt (cfg_long_filt),
  .cfg_swap_en   (cfg_swap_en),
  .sync_q        (sync_q),
  .swap_vec      (swap_vec),
  .filt_lvl      (filt_lvl),
  .dout_level    (dout_level),
  .dout_rise     (dout_rise)
);

// File: tb/sim_din_cond.sv
`timescale 1ns/1ps
module sim_din_cond;

  localparam int N = 4;
  localparam int SW = 4;
  localparam int LW = 8;

  logic         clk;
  logic         rst_n;
  logic         lng;
  logic         swp;
  logic [N-1:0] inv;
  logic [N-1:0] raw;
  logic [N-1:0] lvl;
  logic [N-1:0] rise;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit done  = 0;

  din_cond #(.N_LINES(N), .SHORT_WIN(SW), .LONG_WIN(LW)) u0 (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_long_filt (lng),
    .cfg_swap_en   (swp),
    .cfg_invert    (inv),
    .din_raw       (raw),
    .dout_level    (lvl),
    .dout_rise     (rise)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Reference model built from the requirements
  logic [N-1:0] m1, m2, mf, mfq;
  logic         mr1, mr2;
  int           mcnt [N];

  function automatic logic [N-1:0] swap_of(logic [N-1:0] v, logic en);
    logic [N-1:0] r;
    r = v;
    if (en) begin
      r[1] = v[3];
      r[3] = v[1];
    end
    return r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mr1 <= 1'b0; mr2 <= 1'b0;
      m1 <= '0; m2 <= '0; mf <= '0; mfq <= '0;
      for (int i = 0; i < N; i++) mcnt[i] <= 0;
    end else begin
      mr1 <= 1'b1;
      mr2 <= mr1;
      if (!mr2) begin
        m1 <= '0; m2 <= '0; mf <= '0; mfq <= '0;
        for (int i = 0; i < N; i++) mcnt[i] <= 0;
      end else begin
        logic [N-1:0] s;
        int w;
        s = swap_of(m2, swp);
        w = lng ? LW : SW;
        m1 <= raw;
        m2 <= m1;
        mfq <= mf;
        for (int i = 0; i < N; i++) begin
          if (s[i] == mf[i]) mcnt[i] <= 0;
          else if (mcnt[i] >= w - 1) begin
            mf[i] <= s[i];
            mcnt[i] <= 0;
          end else mcnt[i] <= mcnt[i] + 1;
        end
      end
    end
  end

  // Cycle-by-cycle comparison (R1, R2, R7)
  logic [N-1:0] rise_seen;
  bit model_on = 0;
  always @(negedge clk) begin
    cyc <= cyc + 1;
    rise_seen <= rise_seen | rise;
    if (model_on) begin
      logic [N-1:0] el, er;
      el = mf ^ inv;
      er = (mf ^ mfq) & el;
      total++;
      if (lvl !== el) begin
        bad++;
        $display("FAIL R2 level cyc=%0d actual=%b expected=%b", cyc, lvl, el);
      end
      total++;
      if (rise !== er) begin
        bad++;
        $display("FAIL R7 rise cyc=%0d actual=%b expected=%b", cyc, rise, er);
      end
    end
  end

  task automatic check(string req, logic [N-1:0] act, logic [N-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // Pulse line k for w clocks, then let it settle; returns strobes seen
  task automatic pulse(int k, int w, output logic [N-1:0] seen);
    @(negedge clk);
    rise_seen = '0;
    raw[k] = 1'b1;
    idle(w);
    raw[k] = 1'b0;
    idle(16);
    seen = rise_seen;
  endtask

  initial begin
    logic [N-1:0] seen;
    rise_seen = '0;
    rst_n = 1'b0; lng = 1'b0; swp = 1'b0; inv = 4'b0110; raw = 4'b1111;
    idle(3);
    // R8: in reset, levels follow the mask only, no strobe
    check("R8 reset level", lvl, 4'b0110);
    check("R8 reset rise", rise, 4'b0000);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check("R8 held after release", lvl, 4'b0110);
    inv = 4'b0000; raw = '0;
    idle(2);
    model_on = 1;
    idle(12);

    // R2: exact latency, short window, 2 sync + 4
    @(negedge clk); raw[0] = 1'b1;
    repeat (5) @(posedge clk);
    #1 check("R2 not before 2+W edges", lvl, 4'b0000);
    @(posedge clk); #1 check("R2 at 2+W edges", lvl, 4'b0001);
    @(negedge clk); raw[0] = 1'b0; idle(12);

    // R3: short window boundary
    pulse(2, 3, seen); check("R3 3-clock pulse rejected", seen, 4'b0000);
    pulse(2, 4, seen); check("R3 4-clock pulse accepted", seen, 4'b0100);
    // R4: long window boundary
    lng = 1'b1; idle(2);
    pulse(0, 7, seen); check("R4 7-clock pulse rejected", seen, 4'b0000);
    pulse(0, 8, seen); check("R4 8-clock pulse accepted", seen, 4'b0001);
    lng = 1'b0; idle(2);

    // R6: bounce restarts count
    @(negedge clk); rise_seen = '0;
    raw[1] = 1'b1; idle(3); raw[1] = 1'b0; idle(1); raw[1] = 1'b1; idle(3); raw[1] = 1'b0;
    idle(14);
    check("R6 bounce rejected", rise_seen, 4'b0000);

    // R5: exchange of positions 1 and 3
    swp = 1'b1; raw = 4'b1000; idle(14);
    check("R5 swap on", lvl, swap_of(4'b1000, 1'b1));
    swp = 1'b0; idle(14);
    check("R5 swap off", lvl, 4'b1000);
    raw = 4'b0000; idle(14);

    // R1: polarity applied after the filter, same cycle, no strobe
    @(negedge clk); rise_seen = '0; inv = 4'b0101;
    #1 check("R1 invert immediate", lvl, 4'b0101);
    idle(3);
    check("R7 no strobe on polarity change", rise_seen, 4'b0000);

    // Random phase
    void'($urandom(32'd4242));
    for (int c = 0; c < 4000; c++) begin
      @(negedge clk);
      for (int i = 0; i < N; i++)
        if ($urandom_range(9) == 0) raw[i] = ~raw[i];
      if ($urandom_range(199) == 0) lng = ~lng;
      if ($urandom_range(199) == 0) swp = ~swp;
      if ($urandom_range(149) == 0) inv = N'($urandom);
    end
    idle(4);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule